// File: doc/BRIEF.md
# DMA Cycle Sequencer with External Termination

This block is the state machine that steps a DMA channel through an idle state and a chain of active transfer states. It also takes an external end-of-process request from an open-drain line and decides whether to act on it. A request-valid input starts a transfer. A terminal-count input ends it on the last state of a transfer. An active-low external termination input can also end it, but only if the sequencer is active when it arrives.

The external termination line passes through a synchronizer. While the sequencer is active, the synchronized request is caught and held. It takes effect the next time the sequencer enters S2. If the sequencer goes idle first, the held request is thrown away. Pulses that arrive while the sequencer sits idle are never captured, including pulses that fall between transfers in demand mode. On terminal count, the block pulls the shared line low through an enable output and never drives it high.

Top module: `dma_cycle_seq`

## Requirements
- R1: After reset, `state_o` is SI (code 0), and `term_o` and `eop_oe_o` are 0. The state codes are SI=0, S0=1, S1=2, S2=3, S3=4, S4=5.
- R2: In SI with `req_i` high, the next state is S0. After that, S0→S1→S2→S3→S4 advance one per clock, whatever `req_i` does. S2 goes on to S3 whenever no termination is taken there.
- R3: In S4 with `tc_i` low, the next state is S1 if `req_i` is high and SI if `req_i` is low.
- R4: In S4 with `tc_i` high, `eop_oe_o` and `term_o` are 1 for that cycle and the next state is SI.
- R5: `ext_eop_n_i` is active low and passes through a two-flop synchronizer. While the sequencer is in SI, it is never captured, so a pulse seen only during SI has no effect on a later transfer.
- R6: A synchronized external termination seen while the sequencer is active is held. At the next S2, `term_o` is 1 for one clock and the next state is SI.
- R7: A held external termination is cleared when the sequencer passes through SI. It then has no effect at any later S2.
- R8: `eop_oe_o` is 1 only in S4 with `tc_i` high. `term_o` is 1 only in S2 or S4 and is always followed by SI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transfer request valid |
| tc_i | input | 1 | Word count has reached terminal count |
| ext_eop_n_i | input | 1 | External end-of-process line, active low, asynchronous |
| eop_oe_o | output | 1 | Enable that pulls the end-of-process line low |
| term_o | output | 1 | One-clock pulse when a termination takes effect |
| state_o | output | 3 | Current state code (SI=0, S0..S4=1..5) |

## Verification
The hardest case to reach is a termination that is captured while the sequencer is active and then discarded because the sequencer goes idle before the next S2. The stimulus pulses the external line during S0, so the held request is set by S3. It then drops `req_i` in S4, which forces SI. A new transfer is started and the bench confirms that S2 passes with no termination. The companion case, a pulse that arrives only while the sequencer is idle, is timed so that the synchronizer has settled before the request is raised.

// File: rtl/dma_cycle_seq.sv
module dma_cycle_seq #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_i,
  input  logic       tc_i,
  input  logic       ext_eop_n_i,
  output logic       eop_oe_o,
  output logic       term_o,
  output logic [2:0] state_o
);
  localparam logic [2:0] ST_SI = 3'd0, ST_S0 = 3'd1, ST_S1 = 3'd2,
                         ST_S2 = 3'd3, ST_S3 = 3'd4, ST_S4 = 3'd5;

  logic [2:0]             st_q, st_d;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   held_q;
  logic                   ext_seen;
  logic                   tc_end, ext_end;

  assign ext_seen = ~sync_q[SYNC_STAGES-1];
  assign tc_end   = (st_q == ST_S4) && tc_i;
  assign ext_end  = (st_q == ST_S2) && held_q;
  assign eop_oe_o = tc_end;
  assign term_o   = tc_end || ext_end;
  assign state_o  = st_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_SI: if (req_i) st_d = ST_S0;
      ST_S0: st_d = ST_S1;
      ST_S1: st_d = ST_S2;
      ST_S2: st_d = ext_end ? ST_SI : ST_S3;
      ST_S3: st_d = ST_S4;
      ST_S4: st_d = (tc_i || !req_i) ? ST_SI : ST_S1;
      default: st_d = ST_SI;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_SI;
      sync_q <= '1;
      held_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      sync_q <= {sync_q[SYNC_STAGES-2:0], ext_eop_n_i};
      held_q <= (st_q != ST_SI) && !ext_end && (held_q || ext_seen);
    end
  end
endmodule

module dma_cycle_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_i,
  input logic       tc_i,
  input logic       eop_oe_o,
  input logic       term_o,
  input logic [2:0] state_o
);
  AST_TERM_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    term_o |=> state_o == 3'd0); // R8
  AST_TERM_STATES: assert property (@(posedge clk) disable iff (!rst_n)
    term_o |-> (state_o == 3'd3 || state_o == 3'd5)); // R8
  AST_OE_ONLY_TC_S4: assert property (@(posedge clk) disable iff (!rst_n)
    eop_oe_o |-> (state_o == 3'd5 && tc_i && term_o)); // R4
  AST_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd0 && req_i) |=> state_o == 3'd1); // R2
  AST_S0_TO_S1: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 3'd1 |=> state_o == 3'd2); // R2
  AST_LOOP_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd5 && !tc_i && req_i) |=> state_o == 3'd2); // R3
  AST_IDLE_NO_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 3'd0 |-> !term_o); // R5
endmodule

bind dma_cycle_seq dma_cycle_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .tc_i(tc_i),
  .eop_oe_o(eop_oe_o), .term_o(term_o), .state_o(state_o));

// File: tb/dma_cycle_seq_tb.sv
module dma_cycle_seq_tb;
  logic clk = 0, rst_n = 0, req = 0, tc = 0, eop_n = 1;
  logic oe, term;
  logic [2:0] st;
  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [2:0] SI = 0, S0 = 1, S1 = 2, S2 = 3, S3 = 4, S4 = 5;

  dma_cycle_seq u_dut (.clk(clk), .rst_n(rst_n), .req_i(req), .tc_i(tc),
    .ext_eop_n_i(eop_n), .eop_oe_o(oe), .term_o(term), .state_o(st));

  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_to(input logic [2:0] tgt, input string tag);
    for (int i = 0; i < 20; i++) begin
      if (st == tgt) return;
      @(negedge clk);
    end
    chk({tag, " reach state"}, st, tgt);
  endtask

  task automatic go_idle();
    req = 0; tc = 0; eop_n = 1;
    run_to(SI, "idle");
    step(3);
  endtask

  task automatic t_reset();
    chk("R1 state", st, SI);
    chk("R1 term", term, 0);
    chk("R1 oe", oe, 0);
  endtask

  task automatic t_sequence();
    req = 1;
    step(1); chk("R2 S0", st, S0);
    req = 0;
    step(1); chk("R2 S1", st, S1);
    step(1); chk("R2 S2", st, S2);
    chk("R2 no term at S2", term, 0);
    step(1); chk("R2 S3", st, S3);
    req = 1;
    step(1); chk("R2 S4", st, S4);
    chk("R8 oe low without tc", oe, 0);
    step(1); chk("R3 loop to S1", st, S1);
    step(3); chk("R3 back in S4", st, S4);
    req = 0;
    step(1); chk("R3 idle on req drop", st, SI);
  endtask

  task automatic t_tc();
    req = 1;
    run_to(S4, "R4");
    tc = 1; #1;
    chk("R4 oe in S4", oe, 1);
    chk("R4 term in S4", term, 1);
    step(1); tc = 0;
    chk("R4 idle after tc", st, SI);
    chk("R4 term cleared", term, 0);
  endtask

  task automatic t_ext_active();
    req = 1;
    run_to(S3, "R6");
    eop_n = 0; step(1); eop_n = 1;
    run_to(S2, "R6");
    chk("R6 term at next S2", term, 1);
    step(1);
    chk("R6 idle after ext term", st, SI);
  endtask

  task automatic t_ext_idle();
    req = 0; eop_n = 0;
    step(2); chk("R5 no term in SI", term, 0);
    step(3); eop_n = 1;
    step(4);
    req = 1;
    run_to(S2, "R5");
    chk("R5 idle pulse ignored", term, 0);
    step(1); chk("R5 continue to S3", st, S3);
  endtask

  task automatic t_discard();
    req = 1;
    run_to(S0, "R7");
    eop_n = 0; step(1); eop_n = 1;
    run_to(S4, "R7");
    req = 0;
    step(1); chk("R7 idle before S2", st, SI);
    step(1); req = 1;
    run_to(S2, "R7");
    chk("R7 discarded no term", term, 0);
    step(1); chk("R7 to S3", st, S3);
  endtask

  initial begin
    step(2);
    t_reset();
    rst_n = 1;
    step(1);
    t_sequence(); go_idle();
    t_tc();       go_idle();
    t_ext_active(); go_idle();
    t_ext_idle(); go_idle();
    t_discard();  go_idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule